// File: doc/BRIEF.md
# Computed AES Substitution Unit

This block performs the AES byte substitution without any lookup table. For each byte it computes the multiplicative inverse in GF(2^8) and combines it with an affine map over GF(2). One direction input chooses between the forward substitution, used for encryption, and the inverse substitution, used for decryption. The inverse path runs the inverse affine map first and then the inversion. Both directions share a single inversion core in each byte lane.

The top module holds a parameterised number of independent byte lanes. Sixteen lanes cover a full 128-bit state, and one lane gives a plain 8-bit unit. The result can be taken straight from the combinational logic, or through an optional output register that adds one cycle of latency. Key expansion and the other round steps are handled elsewhere.

Top module: `sbox_array`

## Requirements
- R1: With `inv_mode`=0, every lane outputs A(x^-1), where x^-1 is the inverse in GF(2^8) modulo x^8+x^4+x^3+x+1 (0x11B). A is the affine map b'_i = b_i ^ b_(i+4) ^ b_(i+5) ^ b_(i+6) ^ b_(i+7) ^ c_i with c = 0x63 and indices mod 8. All 256 inputs are covered; for example 0x01 maps to 0x7C, 0x53 to 0xED and 0xFF to 0x16.
- R2: Zero has no inverse and is treated as its own inverse, so the forward result for input 0x00 is 0x63.
- R3: With `inv_mode`=1, every lane outputs (A^-1(x))^-1. A^-1 is b'_i = b_(i+2) ^ b_(i+5) ^ b_(i+7) ^ d_i with d = 0x05. Input 0x63 gives 0x00 and input 0x7C gives 0x01.
- R4: For every byte x, applying the inverse substitution to the forward substitution of x returns x.
- R5: Lane k takes `din[8k+7:8k]` and drives `dout[8k+7:8k]` on its own. Bytes in other lanes do not affect its result, and all lanes follow the same `inv_mode`.
- R6: With `REG_OUT`=1, `dout` shows the substitution of the inputs that were present at the previous rising clock edge. An asynchronous active-low `rst_n` clears `dout` to all zeros.
- R7: With `REG_OUT`=1, `dout` stays unchanged for as long as `din` and `inv_mode` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| inv_mode | input | 1 | 0 selects the forward substitution, 1 the inverse |
| din | input | 8*LANES | Input bytes, lane k in bits 8k+7..8k |
| dout | output | 8*LANES | Substituted bytes, same lane layout |

## Verification
The bench sweeps all 256 byte values in both directions against a model built from a brute-force field inverse. This catches a wrong reduction polynomial or a wrong affine tap, which would corrupt only some bytes and leave others correct. Input zero is checked on its own, because an inverter that gives a nonzero result for zero still passes most other bytes. The round trip and a pair of back-to-back direction changes expose a swapped or misplaced affine stage, which would show up as a broken identity or as a result that lags one cycle behind the mode. Distinct bytes in every lane reveal crossed lane wiring, and the reset value of the register is checked directly.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FIELD_RED  = 8'h1B;   // low bits of 0x11B
    localparam logic [BYTE_W-1:0] FWD_CONST  = 8'h63;
    localparam logic [BYTE_W-1:0] BWD_CONST  = 8'h05;

    typedef logic [BYTE_W-1:0] gf_byte_t;

    // multiply by x with reduction
    function automatic gf_byte_t gf_xtime(input gf_byte_t a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? FIELD_RED : '0);
    endfunction

    // carry-less product reduced by the field polynomial
    function automatic gf_byte_t gf_mul(input gf_byte_t a, input gf_byte_t b);
        gf_byte_t acc;
        gf_byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

endpackage

// File: rtl/gf8_inverter.sv
module gf8_inverter
    import sbox_pkg::*;
(
    input  gf_byte_t val_i,
    output gf_byte_t inv_o
);
    // x^-1 = x^254 = x^2 * x^4 * ... * x^128 ; zero maps to zero
    localparam int STEPS = BYTE_W - 1;

    gf_byte_t pw [STEPS+1];
    gf_byte_t pr [STEPS+1];

    assign pw[0] = val_i;
    assign pr[0] = 8'h01;

    genvar s;
    generate
        for (s = 0; s < STEPS; s++) begin : g_ladder
            assign pw[s+1] = gf_mul(pw[s], pw[s]);
            assign pr[s+1] = gf_mul(pr[s], pw[s+1]);
        end
    endgenerate

    assign inv_o = pr[STEPS];

endmodule

// File: rtl/sbox_affine.sv
module sbox_affine
    import sbox_pkg::*;
#(
    parameter bit BACKWARD = 1'b0
)(
    input  gf_byte_t b_i,
    output gf_byte_t b_o
);
    genvar i;
    generate
        if (!BACKWARD) begin : g_fwd
            for (i = 0; i < BYTE_W; i++) begin : g_bit
                assign b_o[i] = b_i[i] ^ b_i[(i+4)%BYTE_W] ^ b_i[(i+5)%BYTE_W]
                              ^ b_i[(i+6)%BYTE_W] ^ b_i[(i+7)%BYTE_W] ^ FWD_CONST[i];
            end
        end else begin : g_bwd
            for (i = 0; i < BYTE_W; i++) begin : g_bit
                assign b_o[i] = b_i[(i+2)%BYTE_W] ^ b_i[(i+5)%BYTE_W]
                              ^ b_i[(i+7)%BYTE_W] ^ BWD_CONST[i];
            end
        end
    endgenerate

endmodule

// File: rtl/sbox_lane.sv
module sbox_lane
    import sbox_pkg::*;
(
    input  logic     inv_mode,
    input  gf_byte_t x_i,
    output gf_byte_t y_o
);
    gf_byte_t pre_bwd;
    gf_byte_t core_in;
    gf_byte_t core_out;
    gf_byte_t post_fwd;

    sbox_affine #(.BACKWARD(1'b1)) u_pre (
        .b_i (x_i),
        .b_o (pre_bwd)
    );

    assign core_in = inv_mode ? pre_bwd : x_i;

    gf8_inverter u_core (
        .val_i (core_in),
        .inv_o (core_out)
    );

    sbox_affine #(.BACKWARD(1'b0)) u_post (
        .b_i (core_out),
        .b_o (post_fwd)
    );

    assign y_o = inv_mode ? core_out : post_fwd;

endmodule

// File: rtl/sbox_array.sv
module sbox_array
    import sbox_pkg::*;
#(
    parameter int LANES   = 16,
    parameter bit REG_OUT = 1'b1
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inv_mode,
    input  logic [BYTE_W*LANES-1:0] din,
    output logic [BYTE_W*LANES-1:0] dout
);
    localparam int DW = BYTE_W * LANES;

    logic [DW-1:0] lane_out;

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            sbox_lane u_lane (
                .inv_mode (inv_mode),
                .x_i      (din[k*BYTE_W +: BYTE_W]),
                .y_o      (lane_out[k*BYTE_W +: BYTE_W])
            );
        end
    endgenerate

    generate
        if (REG_OUT) begin : g_reg
            typedef struct packed {
                logic [DW-1:0] res;
            } out_st_t;

            out_st_t st_d, st_q;

            always_comb begin
                st_d     = st_q;
                st_d.res = lane_out;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign dout = st_q.res;
        end else begin : g_comb
            assign dout = lane_out;
        end
    endgenerate

endmodule

// File: rtl/sbox_array_chk.sv
module sbox_array_chk #(
    parameter int LANES   = 16,
    parameter bit REG_OUT = 1'b1
)(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 inv_mode,
    input logic [8*LANES-1:0]   din,
    input logic [8*LANES-1:0]   dout,
    input logic [8*LANES-1:0]   comb_out
);
    AST_ZERO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_mode && din[7:0] == 8'h00) |-> comb_out[7:0] == 8'h63); // R2

    AST_INV_OF_63: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_mode && din[7:0] == 8'h63) |-> comb_out[7:0] == 8'h00); // R3

    AST_FWD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_mode && din[7:0] == 8'h01) |-> comb_out[7:0] == 8'h7C); // R1

    generate
        if (REG_OUT) begin : g_reg_chk
            AST_RESET_CLEAR: assert property (@(posedge clk)
                !rst_n |=> dout == '0); // R6

            AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> dout == $past(comb_out)); // R6

            AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $stable(din) && $stable(inv_mode)) |=> $stable(dout)); // R7
        end
    endgenerate

endmodule

bind sbox_array sbox_array_chk #(.LANES(LANES), .REG_OUT(REG_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .inv_mode (inv_mode),
    .din      (din),
    .dout     (dout),
    .comb_out (lane_out)
);

// File: tb/sim_sbox_array.sv
`timescale 1ns/1ps
module sim_sbox_array;

    localparam int LANES = 16;
    localparam int DW    = 8 * LANES;
    localparam int NVEC  = 14;

    // {inv_mode, input, expected}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 8'h63}, {1'b0, 8'h01, 8'h7C}, {1'b0, 8'h02, 8'h77},
        {1'b0, 8'h03, 8'h7B}, {1'b0, 8'h10, 8'hCA}, {1'b0, 8'h20, 8'hB7},
        {1'b0, 8'h53, 8'hED}, {1'b0, 8'h7F, 8'hD2}, {1'b0, 8'h80, 8'hCD},
        {1'b0, 8'hFF, 8'h16}, {1'b1, 8'h63, 8'h00}, {1'b1, 8'h7C, 8'h01},
        {1'b1, 8'hED, 8'h53}, {1'b1, 8'h16, 8'hFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inv_mode = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] m_fwd [256];
    logic [7:0] m_bwd [256];

    always #4 clk = ~clk;

    sbox_array #(.LANES(LANES), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .inv_mode(inv_mode), .din(din), .dout(dout)
    );

    function automatic logic [7:0] tb_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic apply(input logic mode, input logic [DW-1:0] v);
        @(negedge clk);
        inv_mode = mode;
        din      = v;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0]    inv_x;
        logic [DW-1:0] fwd_blk;
        for (int x = 0; x < 256; x++) begin
            inv_x = 8'h00;
            for (int y = 1; y < 256; y++)
                if (tb_mul(8'(x), 8'(y)) == 8'h01) inv_x = 8'(y);
            m_fwd[x] = inv_x ^ rotl(inv_x, 1) ^ rotl(inv_x, 2) ^ rotl(inv_x, 3)
                     ^ rotl(inv_x, 4) ^ 8'h63;
        end
        for (int x = 0; x < 256; x++) m_bwd[m_fwd[x]] = 8'(x);

        // reset state, R6
        repeat (3) @(negedge clk);
        n_run++;
        if (dout !== '0) begin
            n_fail++;
            $display("FAIL R6: reset dout %h expected 0", dout);
        end
        rst_n = 1'b1;

        // table of known values, all lanes carry the same byte
        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v][16], {LANES{VEC[v][15:8]}});
            for (int k = 0; k < LANES; k++)
                check(VEC[v][16] ? "R3 table" : (VEC[v][15:8] == 8'h00 ? "R2 table" : "R1 table"),
                      dout[k*8 +: 8], VEC[v][7:0]);
        end

        // full sweeps, distinct byte per lane (R5)
        for (int blk = 0; blk < 16; blk++) begin
            logic [DW-1:0] v;
            for (int k = 0; k < LANES; k++) v[k*8 +: 8] = 8'(blk * 16 + k);
            apply(1'b0, v);
            for (int k = 0; k < LANES; k++)
                check("R1/R5 forward sweep", dout[k*8 +: 8], m_fwd[blk * 16 + k]);
            fwd_blk = dout;
            apply(1'b1, v);
            for (int k = 0; k < LANES; k++)
                check("R3/R5 inverse sweep", dout[k*8 +: 8], m_bwd[blk * 16 + k]);
            apply(1'b1, fwd_blk);
            for (int k = 0; k < LANES; k++)
                check("R4 round trip", dout[k*8 +: 8], 8'(blk * 16 + k));
        end

        // lane isolation: only lane 5 changes, R5
        apply(1'b0, {LANES{8'h00}});
        apply(1'b0, {LANES{8'h00}} | (DW'(8'h53) << 40));
        for (int k = 0; k < LANES; k++)
            check("R5 isolation", dout[k*8 +: 8], (k == 5) ? 8'hED : 8'h63);

        // back-to-back mode change, R6
        @(negedge clk); inv_mode = 1'b0; din = {LANES{8'h63}};
        @(negedge clk); check("R6 mode fwd", dout[7:0], 8'hFB); inv_mode = 1'b1;
        @(negedge clk); check("R6 mode inv", dout[7:0], 8'h00);

        // hold, R7
        repeat (3) @(negedge clk);
        check("R7 hold", dout[7:0], 8'h00);

        // reset mid-run clears output, R6
        @(negedge clk); rst_n = 1'b0; #1;
        n_run++;
        if (dout !== '0) begin
            n_fail++;
            $display("FAIL R6: async reset dout %h expected 0", dout);
        end
        @(negedge clk); rst_n = 1'b1;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule